// File: doc/BRIEF.md
# Match-Controlled Timer Counter

A register-mapped timer. A prescale counter divides the clock, and each wrap of it advances a 32-bit count. A single match value is compared against the count as it advances. When the count reaches the match value, an action field decides what happens. Any combination of three actions can be chosen: set the sticky match flag (which drives a level interrupt request), return the count to zero, or halt the timer and clear its run bit.

Software controls the block through a word-addressed write port and a combinational read port. A common way to use it is as a one-shot with all three actions enabled. Software, or a DMA engine, sets the run bit. The block then stops by itself and comes to rest with the count at zero and the run bit cleared. Software can poll either of these to learn that the shot is done.

Stop and zero never depend on the state of the match flag. A flag left set from an earlier shot does not block them.

Top module: `tmr_match_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low. The register map is: 0 flag, 1 control, 2 count, 3 prescale limit, 4 prescale count, 5 match, 6 actions, 7 mode.
- R2: Counting runs only while control bit 0 (run) is 1, control bit 1 (hold) is 0 and mode is 0. The prescale count steps from 0 up to the prescale limit and then wraps. The count advances by one on each wrap, so it advances once every limit+1 clocks.
- R3: Actions bit 2 (stop) applies when an advance makes the count equal the match value. On the clock that loads the count, the run bit reads 0, and both counters stay frozen afterwards.
- R4: With actions bit 1 (zero) set, an advance that reaches the match value loads 0 into the count instead of the match value, and counting continues.
- R5: With actions bit 0 (interrupt) set, a match sets flag bit 0. `irq` is high exactly while flag bit 0 and actions bit 0 are both 1.
- R6: With stop and zero both set, the count reads 0 and the run bit reads 0 on the same clock as the match. The flag (if interrupt is enabled) is also set on that clock. This holds even when the flag was already set.
- R7: Flag bit 0 is write-one-to-clear. Writing 0 to the flag leaves it unchanged, and a set flag stays set through further matches.
- R8: While control bit 1 (hold) is 1, the count and prescale count are held at 0.
- R9: The mode register (2 bits) reads back what was written. Any nonzero mode halts counting, and mode 0 counts prescaled clocks.
- R10: Writes to the count and prescale count registers load those values, and the loaded values read back.
- R11: With all action bits 0, a match has no effect: the count passes the match value, the run bit stays 1, and the flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one clock |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The properties assume that the inputs are never unknown after reset and that `wr_en` is the only cause of register change from outside. They also assume that nothing writes the count in the same clock as a match. A count write suppresses that clock's match event, so the match-action properties say nothing about it. The bench keeps inside these limits in two ways. It changes inputs only on falling edges. It configures the timer only while the timer is held or idle, so software loads never coincide with an advance that would match.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        RA_FLAG   = 3'd0,
        RA_CTRL   = 3'd1,
        RA_COUNT  = 3'd2,
        RA_PSLIM  = 3'd3,
        RA_PSCNT  = 3'd4,
        RA_MATCH  = 3'd5,
        RA_ACTION = 3'd6,
        RA_MODE   = 3'd7
    } reg_addr_e;

    // control: bit 1 hold, bit 0 run
    typedef struct packed {
        logic hold;
        logic run;
    } ctrl_t;

    // actions: bit 2 stop, bit 1 zero, bit 0 interrupt
    typedef struct packed {
        logic stop;
        logic zero;
        logic intr;
    } act_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int ACT_W  = $bits(act_t);

    function automatic logic is_write(input logic we, input logic [2:0] a, input reg_addr_e r);
        return we && (a == r);
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         run,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] limit,
    output logic [W-1:0] pc,
    output logic         tick
);
    logic at_limit;

    assign at_limit = (pc >= limit);
    assign tick     = run && !ld && at_limit;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (hold) begin
            pc <= '0;
        end else if (ld) begin
            pc <= ld_val;
        end else if (run) begin
            pc <= at_limit ? '0 : pc + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         tick,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] match_val,
    input  act_t         act,
    output logic [W-1:0] tc,
    output logic         hit
);
    logic [W-1:0] tc_next;

    assign tc_next = tc + 1'b1;
    assign hit     = tick && !ld && !hold && (tc_next == match_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            tc <= '0;
        end else if (hold) begin
            tc <= '0;
        end else if (ld) begin
            tc <= ld_val;
        end else if (tick) begin
            tc <= (hit && act.zero) ? '0 : tc_next;
        end
    end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int W      = 32,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [W-1:0]      wdata,
    input  logic              hit,
    output ctrl_t             ctrl,
    output act_t              act,
    output logic              flag,
    output logic [W-1:0]      match_val,
    output logic [W-1:0]      ps_limit,
    output logic [MODE_W-1:0] mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            act       <= '0;
            flag      <= 1'b0;
            match_val <= '0;
            ps_limit  <= '0;
            mode      <= '0;
        end else begin
            if (is_write(wr_en, addr, RA_CTRL))   ctrl      <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (is_write(wr_en, addr, RA_ACTION)) act       <= act_t'(wdata[ACT_W-1:0]);
            if (is_write(wr_en, addr, RA_MATCH))  match_val <= wdata;
            if (is_write(wr_en, addr, RA_PSLIM))  ps_limit  <= wdata;
            if (is_write(wr_en, addr, RA_MODE))   mode      <= wdata[MODE_W-1:0];
            if (is_write(wr_en, addr, RA_FLAG) && wdata[0]) flag <= 1'b0;
            // match actions take priority and ignore the flag state
            if (hit && act.stop) ctrl.run <= 1'b0;
            if (hit && act.intr) flag     <= 1'b1;
        end
    end
endmodule

// File: rtl/tmr_match_timer.sv
module tmr_match_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    ctrl_t              ctrl_q;
    act_t               act_q;
    logic               flag_q;
    logic [DATA_W-1:0]  match_q;
    logic [DATA_W-1:0]  pslim_q;
    logic [MODE_W-1:0]  mode_q;
    logic [DATA_W-1:0]  pc_q;
    logic [DATA_W-1:0]  tc_q;
    logic               tick;
    logic               hit;
    logic               run;
    logic               ld_tc;
    logic               ld_pc;

    assign run   = ctrl_q.run && !ctrl_q.hold && (mode_q == '0);
    assign ld_tc = is_write(wr_en, addr, RA_COUNT);
    assign ld_pc = is_write(wr_en, addr, RA_PSCNT);

    tmr_regs #(.W(DATA_W), .MODE_W(MODE_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .hit(hit), .ctrl(ctrl_q), .act(act_q), .flag(flag_q),
        .match_val(match_q), .ps_limit(pslim_q), .mode(mode_q)
    );

    tmr_prescaler #(.W(DATA_W)) u_presc (
        .clk(clk), .rst(rst), .hold(ctrl_q.hold), .run(run),
        .ld(ld_pc), .ld_val(wdata), .limit(pslim_q), .pc(pc_q), .tick(tick)
    );

    tmr_counter #(.W(DATA_W)) u_count (
        .clk(clk), .rst(rst), .hold(ctrl_q.hold), .tick(tick),
        .ld(ld_tc), .ld_val(wdata), .match_val(match_q), .act(act_q),
        .tc(tc_q), .hit(hit)
    );

    always_comb begin
        rdata = '0;
        unique case (reg_addr_e'(addr))
            RA_FLAG:   rdata[0]          = flag_q;
            RA_CTRL:   rdata[CTRL_W-1:0] = ctrl_q;
            RA_COUNT:  rdata             = tc_q;
            RA_PSLIM:  rdata             = pslim_q;
            RA_PSCNT:  rdata             = pc_q;
            RA_MATCH:  rdata             = match_q;
            RA_ACTION: rdata[ACT_W-1:0]  = act_q;
            RA_MODE:   rdata[MODE_W-1:0] = mode_q;
            default:   rdata             = '0;
        endcase
    end

    assign irq = flag_q && act_q.intr;
endmodule

// File: rtl/tmr_match_timer_chk.sv
module tmr_match_timer_chk
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [2:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] tc,
    input logic [DATA_W-1:0] pc,
    input logic              run_bit,
    input logic              hold_bit,
    input logic              flag,
    input act_t              act,
    input logic              hit,
    input logic              irq
);
    a_r3_stop_clears_run: assert property (@(posedge clk) disable iff (rst)
        hit && act.stop |=> !run_bit);

    a_r4_zero_on_match: assert property (@(posedge clk) disable iff (rst)
        hit && act.zero |=> tc == '0);

    a_r6_stop_and_zero: assert property (@(posedge clk) disable iff (rst)
        hit && act.stop && act.zero |=> (tc == '0) && !run_bit);

    a_r5_flag_on_match: assert property (@(posedge clk) disable iff (rst)
        hit && act.intr |=> flag);

    a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag && act.intr);

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        flag && !(wr_en && addr == 3'd0 && wdata[0]) |=> flag);

    a_r8_hold_zeroes: assert property (@(posedge clk) disable iff (rst)
        hold_bit |=> (tc == '0) && (pc == '0));

    a_r2_idle_frozen: assert property (@(posedge clk) disable iff (rst)
        !run_bit && !hold_bit && !wr_en |=> $stable(tc) && $stable(pc));
endmodule

bind tmr_match_timer tmr_match_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .tc(tc_q), .pc(pc_q), .run_bit(ctrl_q.run), .hold_bit(ctrl_q.hold),
    .flag(flag_q), .act(act_q), .hit(hit), .irq(irq)
);

// File: tb/tmr_match_timer_bench.sv
`timescale 1ns/100ps
module tmr_match_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_match_timer u_tmr_match_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [31:0] prl;
        logic [31:0] mr;
        logic [2:0]  act;
        logic [15:0] cyc;
        logic [31:0] tc;
        logic        en;
        logic        flag;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'd11, 32'd0, 32'd5,   3'd0, 16'd8,  32'd8, 1'b1, 1'b0}, // R11 passes match
        '{8'd2,  32'd2, 32'd100, 3'd0, 16'd10, 32'd3, 1'b1, 1'b0}, // R2 prescale /3
        '{8'd3,  32'd0, 32'd5,   3'd4, 16'd10, 32'd5, 1'b0, 1'b0}, // R3 stop only
        '{8'd4,  32'd0, 32'd5,   3'd2, 16'd7,  32'd2, 1'b1, 1'b0}, // R4 zero only
        '{8'd5,  32'd0, 32'd5,   3'd1, 16'd7,  32'd7, 1'b1, 1'b1}, // R5 interrupt only
        '{8'd6,  32'd0, 32'd5,   3'd7, 16'd9,  32'd0, 1'b0, 1'b1}, // R6 all three
        '{8'd6,  32'd1, 32'd3,   3'd6, 16'd20, 32'd0, 1'b0, 1'b0}, // R6 stop+zero, prescaled
        '{8'd3,  32'd1, 32'd4,   3'd4, 16'd5,  32'd2, 1'b1, 1'b0}  // R3 before match
    };

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #0.1;
        d = rdata;
    endtask

    task automatic chk(input int req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic cfg(input logic [31:0] prl, input logic [31:0] mr, input logic [2:0] act);
        wr(3'd1, 32'd2);
        wr(3'd1, 32'd0);
        wr(3'd0, 32'd1);
        wr(3'd3, prl);
        wr(3'd5, mr);
        wr(3'd6, {29'd0, act});
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        wait_cyc(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state of every register
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            chk(1, "reset register", v, 32'd0);
        end
        checks++;
        if (irq !== 1'b0) begin errors++; $display("FAIL R1 irq: got %0b expected 0", irq); end

        // vector table
        for (int i = 0; i < NV; i++) begin
            cfg(VECS[i].prl, VECS[i].mr, VECS[i].act);
            wr(3'd1, 32'd1);
            wait_cyc(VECS[i].cyc);
            rd(3'd2, v); chk(VECS[i].req, "count", v, VECS[i].tc);
            rd(3'd1, v); chk(VECS[i].req, "run bit", v, {31'd0, VECS[i].en});
            rd(3'd0, v); chk(VECS[i].req, "flag", v, {31'd0, VECS[i].flag});
        end

        // R6 with flag left pending: same-cycle result
        cfg(0, 5, 3'd7);
        wr(3'd1, 32'd1);
        wait_cyc(5);
        rd(3'd0, v); chk(6, "first shot flag", v, 32'd1);
        wr(3'd1, 32'd1);          // restart without clearing flag
        wait_cyc(4);
        rd(3'd2, v); chk(6, "pending: count before match", v, 32'd4);
        rd(3'd1, v); chk(6, "pending: run before match", v, 32'd1);
        wait_cyc(1);
        rd(3'd2, v); chk(6, "pending: count at match", v, 32'd0);
        rd(3'd1, v); chk(6, "pending: run at match", v, 32'd0);
        rd(3'd0, v); chk(6, "pending: flag at match", v, 32'd1);
        rd(3'd4, v); chk(3, "prescale frozen", v, 32'd0);
        wait_cyc(3);
        rd(3'd2, v); chk(3, "count stays stopped", v, 32'd0);

        // R5 irq level
        checks++;
        if (irq !== 1'b1) begin errors++; $display("FAIL R5 irq with flag: got %0b expected 1", irq); end
        wr(3'd6, 32'd6);
        checks++;
        if (irq !== 1'b0) begin errors++; $display("FAIL R5 irq masked: got %0b expected 0", irq); end
        rd(3'd0, v); chk(5, "flag kept while masked", v, 32'd1);

        // R7 write-one-to-clear
        wr(3'd0, 32'd0);
        rd(3'd0, v); chk(7, "write 0 keeps flag", v, 32'd1);
        wr(3'd0, 32'd1);
        rd(3'd0, v); chk(7, "write 1 clears flag", v, 32'd0);

        // R8 hold
        cfg(0, 100, 3'd0);
        wr(3'd1, 32'd1);
        wait_cyc(4);
        rd(3'd2, v); chk(8, "count before hold", v, 32'd4);
        wr(3'd1, 32'd3);
        wait_cyc(3);
        rd(3'd2, v); chk(8, "count held", v, 32'd0);
        rd(3'd4, v); chk(8, "prescale held", v, 32'd0);
        rd(3'd1, v); chk(8, "control readback", v, 32'd3);

        // R9 mode
        cfg(0, 100, 3'd0);
        wr(3'd7, 32'd1);
        wr(3'd1, 32'd1);
        wait_cyc(6);
        rd(3'd2, v); chk(9, "nonzero mode halts", v, 32'd0);
        rd(3'd7, v); chk(9, "mode readback", v, 32'd1);
        wr(3'd7, 32'd0);
        wait_cyc(3);
        rd(3'd2, v); chk(9, "mode 0 counts", v, 32'd3);

        // R10 loads
        wr(3'd1, 32'd0);
        wr(3'd2, 32'd1234);
        rd(3'd2, v); chk(10, "count load", v, 32'd1234);
        wr(3'd4, 32'd7);
        rd(3'd4, v); chk(10, "prescale load", v, 32'd7);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule